// File: doc/BRIEF.md
# APS and Synchronisation Status Byte Monitor

This block sits behind a frame aligner and watches four overhead bytes of every received frame: the two automatic-protection-switching bytes (called K1 and K2 here), the synchronisation status byte (S1) and the user channel byte (F1). Each byte is presented with its own one-cycle strobe. A byte value is only accepted, and latched into its host-readable register, once the same new value has been seen in a run of consecutive frames. The three low bits of K2 are also integrated over several frames to produce the multiplex-section alarm indication (MS-AIS) and remote defect indication (MS-RDI) status bits.

Every accepted change and every transition of either defect bit sets a sticky event flag. The host clears flags with a write-one-to-clear strobe. The interrupt line is the OR of all flags that are enabled by a per-event mask. While the upstream framer reports loss of frame, all strobes are ignored and every run counter keeps its value. The protection-switching decision and the insertion of these bytes on transmit are handled elsewhere.

Top module: `aps_sync_monitor`

## Requirements
- R1: After synchronous reset, all accepted byte registers read 0x00, both defect bits are 0, all sticky flags are 0 and the interrupt is low.
- R2: A new K1 value is latched into `k1_acc_o` on the third consecutive K1 strobe carrying it, and it sets event flag bit 0 in the same cycle. K_PERSIST defaults to 3.
- R3: K2 is accepted in the same way and sets event flag bit 1. A differing value inside a run restarts the count, and the new value counts as frame one.
- R4: `ms_ais_o` rises after 5 consecutive K2 strobes with K2[2:0]=3'b111 and falls after 5 consecutive K2 strobes without it. Each transition sets event flag bit 2.
- R5: `ms_rdi_o` follows the same rule for K2[2:0]=3'b110 and sets event flag bit 3. MS-AIS and MS-RDI are never both set.
- R6: S1 is accepted after SF_PERSIST (default 3) consecutive identical strobes and sets event flag bit 4.
- R7: F1 is accepted in the same way and sets event flag bit 5. With its strobe low, F1 has no effect.
- R8: Receiving a value equal to the currently accepted one sets no flag and changes no register.
- R9: While `lof_i` is high, every strobe is ignored, and the run counters keep their values across the loss-of-frame cycles.
- R10: Flags are sticky. `clr_we_i` clears the flags selected by `clr_mask_i`. An event in the same cycle as the clear of its bit wins, and the bit stays set.
- R11: `irq_o` is high exactly when some flag is set whose bit in `irq_en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lof_i | input | 1 | Loss of frame from the aligner; freezes monitoring |
| k1_vld_i | input | 1 | K1 strobe |
| k1_i | input | 8 | K1 byte |
| k2_vld_i | input | 1 | K2 strobe |
| k2_i | input | 8 | K2 byte |
| s1_vld_i | input | 1 | S1 strobe |
| s1_i | input | 8 | S1 byte |
| f1_vld_i | input | 1 | F1 strobe |
| f1_i | input | 8 | F1 byte |
| clr_we_i | input | 1 | Host flag-clear strobe |
| clr_mask_i | input | 6 | Flags to clear (write one to clear) |
| irq_en_i | input | 6 | Per-event interrupt enables |
| k1_acc_o | output | 8 | Accepted K1 |
| k2_acc_o | output | 8 | Accepted K2 |
| s1_acc_o | output | 8 | Accepted S1 |
| f1_acc_o | output | 8 | Accepted F1 |
| ms_ais_o | output | 1 | MS-AIS status |
| ms_rdi_o | output | 1 | MS-RDI status |
| evt_flags_o | output | 6 | Sticky event flags |
| irq_o | output | 1 | Interrupt |

## Verification
The assertions check several properties on every cycle. Accepted registers and defect bits change only in a cycle after an accepted strobe, and never while loss of frame is high. The two defect bits are never set together. A flag that is set is latched, and it falls only through a host clear. The run-length rules cannot be shown by a one-cycle property: the exact frame on which a value is accepted, the restart after an interrupted run, the carry-over of a count across a loss-of-frame gap, and the masking of the interrupt. The bench scenarios demonstrate these against a reference model.

// File: rtl/aps_mon_pkg.sv
package aps_mon_pkg;
    localparam int BYTE_W = 8;
    localparam int EV_N   = 6;

    typedef logic [BYTE_W-1:0] ohb_t;
    typedef logic [EV_N-1:0]   ev_vec_t;

    typedef enum int {
        EV_K1  = 0,
        EV_K2  = 1,
        EV_AIS = 2,
        EV_RDI = 3,
        EV_S1  = 4,
        EV_F1  = 5
    } ev_idx_e;

    typedef struct packed {
        ohb_t cand;
        ohb_t acc;
    } byte_track_t;

    localparam logic [2:0] PAT_AIS = 3'b111;
    localparam logic [2:0] PAT_RDI = 3'b110;

    function automatic logic low3_is(input ohb_t b, input logic [2:0] pat);
        return b[2:0] == pat;
    endfunction
endpackage

// File: rtl/persist_filter.sv
module persist_filter
    import aps_mon_pkg::*;
#(
    parameter int TH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic frz_i,
    input  logic vld_i,
    input  ohb_t din_i,
    output ohb_t acc_o,
    output logic chg_o
);
    localparam int CW = $clog2(TH + 1);

    byte_track_t st_q;
    logic [CW-1:0] cnt_q, cnt_nx;
    logic take;

    always_comb begin
        take = vld_i && !frz_i;
        if (din_i == st_q.cand)
            cnt_nx = (cnt_q == CW'(TH)) ? cnt_q : cnt_q + 1'b1;
        else
            cnt_nx = CW'(1);
        chg_o = take && (cnt_nx == CW'(TH)) && (din_i != st_q.acc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            cnt_q <= '0;
        end else if (take) begin
            st_q.cand <= din_i;
            cnt_q     <= cnt_nx;
            if (chg_o) st_q.acc <= din_i;
        end
    end

    assign acc_o = st_q.acc;

    // R2 R3 R6 R7: accepted value moves only after an accepted strobe
    p_acc_needs_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.acc) |-> $past(take));
    // R9: frozen cycle leaves run state untouched
    p_frozen_hold_r9: assert property (@(posedge clk) disable iff (rst)
        $past(frz_i) |-> ($stable(st_q) && $stable(cnt_q)));
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(TH));
endmodule

// File: rtl/defect_filter.sv
module defect_filter #(
    parameter int N = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic frz_i,
    input  logic vld_i,
    input  logic match_i,
    output logic state_o,
    output logic chg_o
);
    localparam int CW = $clog2(N + 1);

    logic state_q;
    logic [CW-1:0] cnt_q;
    logic take;

    always_comb begin
        take  = vld_i && !frz_i;
        chg_o = take && (match_i != state_q) && (cnt_q == CW'(N - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= 1'b0;
            cnt_q   <= '0;
        end else if (take) begin
            if (match_i != state_q) begin
                if (chg_o) begin
                    state_q <= match_i;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign state_o = state_q;

    // R4 R5: defect state only moves after an accepted K2 strobe
    p_defect_needs_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(state_q) |-> $past(take));
    // R9
    p_defect_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        $past(frz_i) |-> ($stable(state_q) && $stable(cnt_q)));
endmodule

// File: rtl/evt_flags.sv
module evt_flags
    import aps_mon_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ev_vec_t set_i,
    input  logic    clr_we_i,
    input  ev_vec_t clr_mask_i,
    input  ev_vec_t en_i,
    output ev_vec_t flags_o,
    output logic    irq_o
);
    ev_vec_t flags_q, clr_eff;

    assign clr_eff = clr_we_i ? clr_mask_i : '0;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr_eff) | set_i;
    end

    assign flags_o = flags_q;
    assign irq_o   = |(flags_q & en_i);

    // R10: a flag only falls through a host clear
    p_no_spurious_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (($past(flags_q) & ~flags_q & ~$past(clr_eff)) == '0));

    for (genvar g = 0; g < EV_N; g++) begin : g_stick
        // R10: event wins over clear
        p_set_sticks_r10: assert property (@(posedge clk) disable iff (rst)
            set_i[g] |=> flags_q[g]);
    end
endmodule

// File: rtl/aps_sync_monitor.sv
module aps_sync_monitor
    import aps_mon_pkg::*;
#(
    parameter int K_PERSIST   = 3,
    parameter int SF_PERSIST  = 3,
    parameter int DEF_PERSIST = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lof_i,
    input  logic       k1_vld_i,
    input  logic [7:0] k1_i,
    input  logic       k2_vld_i,
    input  logic [7:0] k2_i,
    input  logic       s1_vld_i,
    input  logic [7:0] s1_i,
    input  logic       f1_vld_i,
    input  logic [7:0] f1_i,
    input  logic       clr_we_i,
    input  logic [5:0] clr_mask_i,
    input  logic [5:0] irq_en_i,
    output logic [7:0] k1_acc_o,
    output logic [7:0] k2_acc_o,
    output logic [7:0] s1_acc_o,
    output logic [7:0] f1_acc_o,
    output logic       ms_ais_o,
    output logic       ms_rdi_o,
    output logic [5:0] evt_flags_o,
    output logic       irq_o
);
    localparam int NB = 4;

    logic [NB-1:0] vld;
    ohb_t          din [NB];
    ohb_t          acc [NB];
    logic [NB-1:0] bchg;
    logic [1:0]    dmatch, dstate, dchg;
    ev_vec_t       ev;

    assign vld    = {f1_vld_i, s1_vld_i, k2_vld_i, k1_vld_i};
    assign din[0] = k1_i;
    assign din[1] = k2_i;
    assign din[2] = s1_i;
    assign din[3] = f1_i;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        localparam int TH = (i < 2) ? K_PERSIST : SF_PERSIST;
        persist_filter #(.TH(TH)) u_pf (
            .clk(clk), .rst(rst), .frz_i(lof_i), .vld_i(vld[i]),
            .din_i(din[i]), .acc_o(acc[i]), .chg_o(bchg[i])
        );
    end

    assign dmatch[0] = low3_is(k2_i, PAT_AIS);
    assign dmatch[1] = low3_is(k2_i, PAT_RDI);

    for (genvar d = 0; d < 2; d++) begin : g_def
        defect_filter #(.N(DEF_PERSIST)) u_df (
            .clk(clk), .rst(rst), .frz_i(lof_i), .vld_i(k2_vld_i),
            .match_i(dmatch[d]), .state_o(dstate[d]), .chg_o(dchg[d])
        );
    end

    always_comb begin
        ev         = '0;
        ev[EV_K1]  = bchg[0];
        ev[EV_K2]  = bchg[1];
        ev[EV_AIS] = dchg[0];
        ev[EV_RDI] = dchg[1];
        ev[EV_S1]  = bchg[2];
        ev[EV_F1]  = bchg[3];
    end

    evt_flags u_flags (
        .clk(clk), .rst(rst), .set_i(ev), .clr_we_i(clr_we_i),
        .clr_mask_i(clr_mask_i), .en_i(irq_en_i),
        .flags_o(evt_flags_o), .irq_o(irq_o)
    );

    assign k1_acc_o = acc[0];
    assign k2_acc_o = acc[1];
    assign s1_acc_o = acc[2];
    assign f1_acc_o = acc[3];
    assign ms_ais_o = dstate[0];
    assign ms_rdi_o = dstate[1];

    // R5: the two defect patterns are exclusive
    p_ais_rdi_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(ms_ais_o && ms_rdi_o));
endmodule

// File: tb/aps_sync_monitor_tb_top.sv
`timescale 1ns/1ps
module aps_sync_monitor_tb_top;
    localparam int KP = 3, SP = 3, DP = 5;

    logic clk = 1'b0, rst = 1'b1, lof = 1'b0;
    logic k1v = 0, k2v = 0, s1v = 0, f1v = 0;
    logic [7:0] k1 = 0, k2 = 0, s1 = 0, f1 = 0;
    logic clr_we = 0;
    logic [5:0] clr_mask = 0, irq_en = 6'h3F;
    logic [7:0] k1a, k2a, s1a, f1a;
    logic ais, rdi, irq;
    logic [5:0] flags;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    aps_sync_monitor #(.K_PERSIST(KP), .SF_PERSIST(SP), .DEF_PERSIST(DP)) dut_i (
        .clk(clk), .rst(rst), .lof_i(lof),
        .k1_vld_i(k1v), .k1_i(k1), .k2_vld_i(k2v), .k2_i(k2),
        .s1_vld_i(s1v), .s1_i(s1), .f1_vld_i(f1v), .f1_i(f1),
        .clr_we_i(clr_we), .clr_mask_i(clr_mask), .irq_en_i(irq_en),
        .k1_acc_o(k1a), .k2_acc_o(k2a), .s1_acc_o(s1a), .f1_acc_o(f1a),
        .ms_ais_o(ais), .ms_rdi_o(rdi), .evt_flags_o(flags), .irq_o(irq)
    );

    typedef struct {
        string      tag;
        logic [7:0] b [4];
        logic       ais, rdi, irq;
        logic [5:0] fl;
    } exp_t;
    exp_t q[$];

    // reference model state
    logic [7:0] m_acc [4], m_cand [4];
    int         m_cnt [4];
    logic       m_ais, m_rdi;
    int         m_ac, m_rc;
    logic [5:0] m_fl;

    task automatic chk(input string req, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s]: actual %h expected %h", req, tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk("R2", e.tag, k1a, e.b[0]);
            chk("R3", e.tag, k2a, e.b[1]);
            chk("R6", e.tag, s1a, e.b[2]);
            chk("R7", e.tag, f1a, e.b[3]);
            chk("R4", e.tag, {7'd0, ais}, {7'd0, e.ais});
            chk("R5", e.tag, {7'd0, rdi}, {7'd0, e.rdi});
            chk("R10", e.tag, {2'd0, flags}, {2'd0, e.fl});
            chk("R11", e.tag, {7'd0, irq}, {7'd0, e.irq});
        end
    end

    task automatic mdl_byte(input int i, input logic [7:0] v, inout logic [5:0] ev, input int bit_i);
        int th;
        th = (i < 2) ? KP : SP;
        if (v == m_cand[i]) begin
            if (m_cnt[i] < th) m_cnt[i]++;
        end else begin
            m_cand[i] = v;
            m_cnt[i]  = 1;
        end
        if (m_cnt[i] == th && v != m_acc[i]) begin
            m_acc[i] = v;
            ev[bit_i] = 1'b1;
        end
    endtask

    task automatic mdl_def(input logic match, inout logic st, inout int c, inout logic [5:0] ev, input int bit_i);
        if (match != st) begin
            c++;
            if (c == DP) begin
                st = match;
                c  = 0;
                ev[bit_i] = 1'b1;
            end
        end else c = 0;
    endtask

    // vm: [0]=K1 [1]=K2 [2]=S1 [3]=F1 strobes
    task automatic frame(input logic [7:0] a, b, c, d, input logic [3:0] vm,
                         input logic lf, input logic [5:0] clr, input string tag);
        logic [5:0] ev;
        exp_t e;
        @(negedge clk); #1;
        k1 = a; k2 = b; s1 = c; f1 = d;
        {f1v, s1v, k2v, k1v} = vm;
        lof = lf; clr_we = (clr != 0); clr_mask = clr;
        @(posedge clk); #1;
        {f1v, s1v, k2v, k1v} = 4'b0;
        lof = 0; clr_we = 0; clr_mask = 0;
        ev = '0;
        if (!lf) begin
            if (vm[0]) mdl_byte(0, a, ev, 0);
            if (vm[1]) mdl_byte(1, b, ev, 1);
            if (vm[2]) mdl_byte(2, c, ev, 4);
            if (vm[3]) mdl_byte(3, d, ev, 5);
            if (vm[1]) begin
                mdl_def(b[2:0] == 3'b111, m_ais, m_ac, ev, 2);
                mdl_def(b[2:0] == 3'b110, m_rdi, m_rc, ev, 3);
            end
        end
        m_fl = (m_fl & ~clr) | ev;
        e.tag = tag;
        for (int i = 0; i < 4; i++) e.b[i] = m_acc[i];
        e.ais = m_ais; e.rdi = m_rdi; e.fl = m_fl;
        e.irq = |(m_fl & irq_en);
        q.push_back(e);
    endtask

    task automatic set_en(input logic [5:0] v);
        @(negedge clk); #1;
        irq_en = v;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_acc[i] = 0; m_cand[i] = 0; m_cnt[i] = 0; end
        m_ais = 0; m_rdi = 0; m_ac = 0; m_rc = 0; m_fl = 0;
        repeat (4) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "reset", k1a | k2a | s1a | f1a, 8'h00);
        chk("R1", "reset", {2'd0, flags}, 8'h00);
        chk("R1", "reset", {6'd0, ais, rdi}, 8'h00);
        chk("R1", "reset", {7'd0, irq}, 8'h00);

        // R2 R3 R6 R7 first acceptance on third frame
        repeat (3) frame(8'h5A, 8'h20, 8'h0F, 8'h33, 4'hF, 0, 0, "R2 R3 R6 R7 accept");
        // R8 repeat of accepted values, with a full clear (R10)
        frame(8'h5A, 8'h20, 8'h0F, 8'h33, 4'hF, 0, 6'h3F, "R8 R10 clear and repeat");
        frame(8'h5A, 8'h20, 8'h0F, 8'h33, 4'hF, 0, 0, "R8 no event");
        // R3 interrupted run restarts
        frame(8'h8C, 8'h41, 8'h0F, 8'h33, 4'hF, 0, 0, "R3 run 1");
        frame(8'h8C, 8'h41, 8'h0F, 8'h33, 4'hF, 0, 0, "R3 run 2");
        frame(8'h11, 8'h42, 8'h0F, 8'h33, 4'hF, 0, 0, "R3 break");
        repeat (3) frame(8'h8C, 8'h41, 8'h0F, 8'h33, 4'hF, 0, 0, "R2 R3 restart");
        // R11 masked interrupt: only MS-AIS enabled
        frame(8'h8C, 8'h41, 8'h0F, 8'h33, 4'hF, 0, 6'h3F, "R10 clear");
        set_en(6'b000100);
        repeat (5) frame(8'h8C, 8'h27, 8'h0F, 8'h33, 4'hF, 0, 0, "R4 R11 AIS assert");
        repeat (5) frame(8'h8C, 8'h20, 8'h0F, 8'h33, 4'hF, 0, 0, "R4 AIS release");
        set_en(6'h3F);
        frame(8'h8C, 8'h20, 8'h0F, 8'h33, 4'hF, 0, 6'h3F, "R10 clear");
        repeat (5) frame(8'h8C, 8'h26, 8'h0F, 8'h33, 4'hF, 0, 0, "R5 RDI assert");
        // R5 switch straight to AIS pattern
        repeat (5) frame(8'h8C, 8'h27, 8'h0F, 8'h33, 4'hF, 0, 0, "R5 RDI to AIS");
        // R9 loss-of-frame gap keeps the S1 run
        frame(8'h8C, 8'h27, 8'h0F, 8'h33, 4'hF, 0, 6'h3F, "R10 clear");
        frame(8'h8C, 8'h27, 8'h0A, 8'h33, 4'hF, 0, 0, "R9 run 1");
        frame(8'h8C, 8'h27, 8'h0A, 8'h33, 4'hF, 0, 0, "R9 run 2");
        frame(8'h99, 8'h20, 8'h55, 8'h66, 4'hF, 1, 0, "R9 frozen");
        frame(8'h8C, 8'h27, 8'h0A, 8'h33, 4'hF, 0, 0, "R9 run 3 accept");
        // R7 F1 ignored with strobe low
        repeat (3) frame(8'h8C, 8'h27, 8'h0A, 8'h77, 4'b0111, 0, 0, "R7 strobe low");
        // R10 event and clear of the same bit together
        frame(8'h8C, 8'h27, 8'h0B, 8'h33, 4'hF, 0, 0, "R6 run 1");
        frame(8'h8C, 8'h27, 8'h0B, 8'h33, 4'hF, 0, 0, "R6 run 2");
        frame(8'h8C, 8'h27, 8'h0B, 8'h33, 4'hF, 0, 6'h3F, "R10 set wins");
        frame(8'h8C, 8'h27, 8'h0B, 8'h33, 4'hF, 0, 6'b010000, "R10 partial clear");
        set_en(6'h00);
        frame(8'h8C, 8'h27, 8'h0B, 8'h33, 4'hF, 0, 0, "R11 all masked");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule